// File: doc/BRIEF.md
# Linked-List Sharer Directory

This block tracks which nodes hold a copy of each of a small set of cache lines. It does not keep a bit per node. The directory keeps one head pointer per tracked line. Each node's copy of a line carries a forward pointer and a backward pointer, so the sharers of a line form a doubly linked list. The pointers that real caches would store beside their tags are modelled here as a pointer table inside the block. Data movement, the caches themselves and the network are not modelled.

Three kinds of request arrive on a single request port:
- **Read miss.** The requester is pushed onto the front of the list in one cycle.
- **Eviction.** The node is spliced out of the list in one cycle. Its neighbours' pointers are repaired, and the head pointer is moved if the evicted node was the front of the list.
- **Write miss.** A walk starts at the head. It sends one invalidation at a time, waits for that node's acknowledgement, removes the node and moves on. When the list is empty, the writer is installed as the only sharer.

A query port reads back the head pointer and the node pointers, so the list can be inspected from outside the block.

Top module: `sparse_sharer_dir`

## Requirements
- R1: After reset every line's head reads as the null pointer, and no node is present on any line.
- R2: A read miss accepted in cycle k inserts the requester at the front of the list. Its backward pointer becomes null, its forward pointer becomes the old head, and the old head's backward pointer names the requester. `op_done` is high for the cycle after acceptance.
- R3: A read miss from a node that is already on the list leaves every pointer of that line unchanged.
- R4: A write miss sends one invalidation to each sharer other than the writer. The invalidations go in list order from head to tail, and `inv_line` gives the line. `op_done` pulses once when the walk ends.
- R5: While `inv_valid` is high and `inv_ack` is low, `inv_valid` stays high and `inv_node` is unchanged. Only one invalidation is outstanding at any time.
- R6: The writer never receives an invalidation. After the write, the list holds only the writer, with both of its pointers null.
- R7: Evicting a node in the middle or at the tail links its predecessor's forward pointer to its successor, and its successor's backward pointer to its predecessor.
- R8: Evicting the head moves the head pointer to the next node and sets that node's backward pointer to null. Evicting the last sharer frees the entry, so the head reads null.
- R9: Evicting a node that is not on the list, or a request with op code 3, changes nothing. The request still completes with `op_done`.
- R10: `req_ready` is low while a write walk is in progress, and request pulses presented then have no effect.
- R11: A pointer uses one bit more than a node index. The all-ones value (7 for 4 nodes) is the null pointer that marks the end of a list. Op codes are: read 0, write 1, evict 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (no walk in progress) |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 eviction, 3 no operation |
| req_line | input | 2 | Tracked line index |
| req_node | input | 2 | Requesting node |
| op_done | output | 1 | One-cycle pulse when a request completes |
| inv_valid | output | 1 | Invalidation outstanding |
| inv_node | output | 2 | Node to invalidate |
| inv_line | output | 2 | Line being invalidated |
| inv_ack | input | 1 | Acknowledgement of the outstanding invalidation |
| q_line | input | 2 | Line to inspect |
| q_node | input | 2 | Node to inspect |
| q_head | output | 3 | Head pointer of q_line |
| q_present | output | 1 | q_node is on q_line's list |
| q_next | output | 3 | Forward pointer of q_node on q_line |
| q_prev | output | 3 | Backward pointer of q_node on q_line |

## Verification
The hardest condition to produce is a write walk in which the writer itself sits in the middle of a long list. In that case the walk must remove the writer without sending it an invalidation, and keep walking. A stalled acknowledgement must also hold the walk in place while other requests are presented.

Directed sequences build four-node lists with the writer at chosen positions and stretch the acknowledgement delay. A request pulse is driven during each stall. A long pseudo-random sweep over all lines, nodes and operations then compares every pointer against a reference ordering after each operation.

// File: rtl/sdir_pkg.sv
package sdir_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NONE  = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        LC_NOP    = 2'd0,
        LC_INSERT = 2'd1,
        LC_UNLINK = 2'd2,
        LC_SOLE   = 2'd3
    } list_cmd_e;

    typedef enum logic [1:0] {
        WS_IDLE     = 2'd0,
        WS_WALK     = 2'd1,
        WS_WAIT_ACK = 2'd2
    } walk_state_e;

    function automatic int ptr_width(input int nodes);
        return $clog2(nodes) + 1;
    endfunction

endpackage

// File: rtl/sdir_list_store.sv
module sdir_list_store
    import sdir_pkg::*;
#(
    parameter int NODES = 4,
    parameter int LINES = 4,
    parameter int NIW   = $clog2(NODES),
    parameter int LW    = $clog2(LINES),
    parameter int PW    = NIW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  list_cmd_e       cmd_kind,
    input  logic [LW-1:0]   cmd_line,
    input  logic [NIW-1:0]  cmd_node,
    input  logic [LW-1:0]   walk_line,
    output logic [PW-1:0]   walk_head,
    input  logic [LW-1:0]   q_line,
    input  logic [NIW-1:0]  q_node,
    output logic [PW-1:0]   q_head,
    output logic            q_present,
    output logic [PW-1:0]   q_next,
    output logic [PW-1:0]   q_prev
);

    localparam logic [PW-1:0] NULLP = {PW{1'b1}};

    logic [PW-1:0]    head_q [LINES];
    logic [PW-1:0]    nxt_q  [LINES][NODES];
    logic [PW-1:0]    prv_q  [LINES][NODES];
    logic [NODES-1:0] vld_q  [LINES];

    logic             member;
    logic [PW-1:0]    c_nxt, c_prv, old_head;

    always_comb begin
        member   = vld_q[cmd_line][cmd_node];
        c_nxt    = nxt_q[cmd_line][cmd_node];
        c_prv    = prv_q[cmd_line][cmd_node];
        old_head = head_q[cmd_line];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < LINES; l++) begin
                head_q[l] <= NULLP;
                vld_q[l]  <= '0;
                for (int n = 0; n < NODES; n++) begin
                    nxt_q[l][n] <= NULLP;
                    prv_q[l][n] <= NULLP;
                end
            end
        end else begin
            case (cmd_kind)
                LC_INSERT: begin
                    if (!member) begin
                        vld_q[cmd_line][cmd_node] <= 1'b1;
                        nxt_q[cmd_line][cmd_node] <= old_head;
                        prv_q[cmd_line][cmd_node] <= NULLP;
                        if (old_head != NULLP)
                            prv_q[cmd_line][old_head[NIW-1:0]] <= PW'(cmd_node);
                        head_q[cmd_line] <= PW'(cmd_node);
                    end
                end
                LC_UNLINK: begin
                    if (member) begin
                        vld_q[cmd_line][cmd_node] <= 1'b0;
                        nxt_q[cmd_line][cmd_node] <= NULLP;
                        prv_q[cmd_line][cmd_node] <= NULLP;
                        if (c_prv == NULLP)
                            head_q[cmd_line] <= c_nxt;
                        else
                            nxt_q[cmd_line][c_prv[NIW-1:0]] <= c_nxt;
                        if (c_nxt != NULLP)
                            prv_q[cmd_line][c_nxt[NIW-1:0]] <= c_prv;
                    end
                end
                LC_SOLE: begin
                    vld_q[cmd_line][cmd_node] <= 1'b1;
                    nxt_q[cmd_line][cmd_node] <= NULLP;
                    prv_q[cmd_line][cmd_node] <= NULLP;
                    head_q[cmd_line]          <= PW'(cmd_node);
                end
                default: ;
            endcase
        end
    end

    assign walk_head = head_q[walk_line];
    assign q_head    = head_q[q_line];
    assign q_present = vld_q[q_line][q_node];
    assign q_next    = nxt_q[q_line][q_node];
    assign q_prev    = prv_q[q_line][q_node];

    for (genvar g = 0; g < LINES; g++) begin : g_line_chk
        AST_HEAD_IS_FRONT: assert property (@(posedge clk) disable iff (rst)
            head_q[g] != NULLP |-> vld_q[g][head_q[g][NIW-1:0]] && prv_q[g][head_q[g][NIW-1:0]] == NULLP) // R8
            else $error("head of line %0d is not a front node", g);
        AST_INSERT_AT_FRONT: assert property (@(posedge clk) disable iff (rst)
            (cmd_kind == LC_INSERT && cmd_line == LW'(g) && !vld_q[g][cmd_node])
            |=> head_q[g] == PW'($past(cmd_node))) // R2
            else $error("read miss not placed at front on line %0d", g);
        AST_STRANGER_EVICT_QUIET: assert property (@(posedge clk) disable iff (rst)
            (cmd_kind == LC_UNLINK && cmd_line == LW'(g) && !vld_q[g][cmd_node])
            |=> $stable(head_q[g]) && $stable(vld_q[g])) // R9
            else $error("eviction of non-sharer altered line %0d", g);
    end

endmodule

// File: rtl/sdir_walk_ctrl.sv
module sdir_walk_ctrl
    import sdir_pkg::*;
#(
    parameter int NODES = 4,
    parameter int LINES = 4,
    parameter int NIW   = $clog2(NODES),
    parameter int LW    = $clog2(LINES),
    parameter int PW    = NIW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_op,
    input  logic [LW-1:0]   req_line,
    input  logic [NIW-1:0]  req_node,
    output logic            op_done,
    output logic            inv_valid,
    output logic [NIW-1:0]  inv_node,
    output logic [LW-1:0]   inv_line,
    input  logic            inv_ack,
    output list_cmd_e       cmd_kind,
    output logic [LW-1:0]   cmd_line,
    output logic [NIW-1:0]  cmd_node,
    output logic [LW-1:0]   walk_line,
    input  logic [PW-1:0]   walk_head
);

    localparam logic [PW-1:0] NULLP = {PW{1'b1}};

    walk_state_e     state_q;
    logic [LW-1:0]   wr_line_q;
    logic [NIW-1:0]  wr_node_q;
    logic [NIW-1:0]  inv_node_q;
    logic            done_q;
    logic            accept;
    req_op_e         op;

    assign op        = req_op_e'(req_op);
    assign req_ready = (state_q == WS_IDLE);
    assign accept    = req_valid && req_ready;
    assign walk_line = wr_line_q;
    assign inv_valid = (state_q == WS_WAIT_ACK);
    assign inv_node  = inv_node_q;
    assign inv_line  = wr_line_q;
    assign op_done   = done_q;

    always_comb begin
        cmd_kind = LC_NOP;
        cmd_line = wr_line_q;
        cmd_node = wr_node_q;
        case (state_q)
            WS_IDLE: begin
                cmd_line = req_line;
                cmd_node = req_node;
                if (accept) begin
                    if (op == OP_READ)       cmd_kind = LC_INSERT;
                    else if (op == OP_EVICT) cmd_kind = LC_UNLINK;
                end
            end
            WS_WALK: begin
                if (walk_head == NULLP) begin
                    cmd_kind = LC_SOLE;
                end else if (walk_head == PW'(wr_node_q)) begin
                    cmd_kind = LC_UNLINK;
                end
            end
            WS_WAIT_ACK: begin
                cmd_node = inv_node_q;
                if (inv_ack) cmd_kind = LC_UNLINK;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= WS_IDLE;
            wr_line_q  <= '0;
            wr_node_q  <= '0;
            inv_node_q <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                WS_IDLE: begin
                    if (accept) begin
                        if (op == OP_WRITE) begin
                            state_q   <= WS_WALK;
                            wr_line_q <= req_line;
                            wr_node_q <= req_node;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                end
                WS_WALK: begin
                    if (walk_head == NULLP) begin
                        state_q <= WS_IDLE;
                        done_q  <= 1'b1;
                    end else if (walk_head != PW'(wr_node_q)) begin
                        inv_node_q <= walk_head[NIW-1:0];
                        state_q    <= WS_WAIT_ACK;
                    end
                end
                WS_WAIT_ACK: begin
                    if (inv_ack) state_q <= WS_WALK;
                end
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    AST_INV_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        inv_valid && !inv_ack |=> inv_valid && $stable(inv_node)) // R5
        else $error("invalidation dropped or changed before acknowledgement");
    AST_BUSY_DURING_WALK: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> !req_ready) // R10
        else $error("ready asserted during a walk");
    AST_WRITER_NOT_INVALIDATED: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> inv_node != wr_node_q) // R6
        else $error("writer received an invalidation");
    AST_DONE_AFTER_WALK_ONLY: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> !op_done) // R4
        else $error("completion reported with invalidation outstanding");

endmodule

// File: rtl/sparse_sharer_dir.sv
module sparse_sharer_dir
    import sdir_pkg::*;
#(
    parameter int NODES = 4,
    parameter int LINES = 4,
    parameter int NIW   = $clog2(NODES),
    parameter int LW    = $clog2(LINES),
    parameter int PW    = ptr_width(NODES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_op,
    input  logic [LW-1:0]   req_line,
    input  logic [NIW-1:0]  req_node,
    output logic            op_done,
    output logic            inv_valid,
    output logic [NIW-1:0]  inv_node,
    output logic [LW-1:0]   inv_line,
    input  logic            inv_ack,
    input  logic [LW-1:0]   q_line,
    input  logic [NIW-1:0]  q_node,
    output logic [PW-1:0]   q_head,
    output logic            q_present,
    output logic [PW-1:0]   q_next,
    output logic [PW-1:0]   q_prev
);

    list_cmd_e      cmd_kind;
    logic [LW-1:0]  cmd_line;
    logic [NIW-1:0] cmd_node;
    logic [LW-1:0]  walk_line;
    logic [PW-1:0]  walk_head;

    sdir_walk_ctrl #(
        .NODES(NODES), .LINES(LINES), .NIW(NIW), .LW(LW), .PW(PW)
    ) ctrl_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_line(req_line), .req_node(req_node), .op_done(op_done),
        .inv_valid(inv_valid), .inv_node(inv_node), .inv_line(inv_line),
        .inv_ack(inv_ack),
        .cmd_kind(cmd_kind), .cmd_line(cmd_line), .cmd_node(cmd_node),
        .walk_line(walk_line), .walk_head(walk_head)
    );

    sdir_list_store #(
        .NODES(NODES), .LINES(LINES), .NIW(NIW), .LW(LW), .PW(PW)
    ) store_i (
        .clk(clk), .rst(rst),
        .cmd_kind(cmd_kind), .cmd_line(cmd_line), .cmd_node(cmd_node),
        .walk_line(walk_line), .walk_head(walk_head),
        .q_line(q_line), .q_node(q_node), .q_head(q_head),
        .q_present(q_present), .q_next(q_next), .q_prev(q_prev)
    );

endmodule

// File: tb/sparse_sharer_dir_tb_top.sv
module sparse_sharer_dir_tb_top;

    localparam int N    = 4;
    localparam int L    = 4;
    localparam int NULV = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_op = 2'd0;
    logic [1:0] req_line = 2'd0;
    logic [1:0] req_node = 2'd0;
    logic       op_done;
    logic       inv_valid;
    logic [1:0] inv_node;
    logic [1:0] inv_line;
    logic       inv_ack = 1'b0;
    logic [1:0] q_line = 2'd0;
    logic [1:0] q_node = 2'd0;
    logic [2:0] q_head;
    logic       q_present;
    logic [2:0] q_next;
    logic [2:0] q_prev;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    int ord [L][N];
    int cnt [L];
    int exp_inv [N];
    int exp_cnt;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    sparse_sharer_dir dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_line(req_line), .req_node(req_node), .op_done(op_done),
        .inv_valid(inv_valid), .inv_node(inv_node), .inv_line(inv_line),
        .inv_ack(inv_ack),
        .q_line(q_line), .q_node(q_node), .q_head(q_head),
        .q_present(q_present), .q_next(q_next), .q_prev(q_prev)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pos_of(input int ln, input int nd);
        for (int i = 0; i < cnt[ln]; i++) if (ord[ln][i] == nd) return i;
        return -1;
    endfunction

    task automatic check_lists(input string req);
        for (int ln = 0; ln < L; ln++) begin
            int eh;
            q_line = 2'(ln);
            #1;
            eh = (cnt[ln] > 0) ? ord[ln][0] : NULV;
            check(int'(q_head) == eh, {req, " head"}, int'(q_head), eh);
            for (int nd = 0; nd < N; nd++) begin
                int p, en, ep;
                q_node = 2'(nd);
                #1;
                p = pos_of(ln, nd);
                if (p < 0) begin
                    check(q_present == 1'b0, {req, " absent"}, int'(q_present), 0);
                end else begin
                    en = (p + 1 < cnt[ln]) ? ord[ln][p+1] : NULV;
                    ep = (p > 0) ? ord[ln][p-1] : NULV;
                    check(q_present && int'(q_next) == en && int'(q_prev) == ep,
                          {req, " links"}, int'(q_next) * 10 + int'(q_prev), en * 10 + ep);
                end
            end
        end
    endtask

    task automatic ref_read(input int ln, input int nd);
        if (pos_of(ln, nd) >= 0) return;
        for (int i = cnt[ln]; i > 0; i--) ord[ln][i] = ord[ln][i-1];
        ord[ln][0] = nd;
        cnt[ln]++;
    endtask

    task automatic ref_evict(input int ln, input int nd);
        int p;
        p = pos_of(ln, nd);
        if (p < 0) return;
        for (int i = p; i < cnt[ln] - 1; i++) ord[ln][i] = ord[ln][i+1];
        cnt[ln]--;
    endtask

    task automatic simple_op(input int op, input int ln, input int nd, input string req);
        @(negedge clk);
        check(req_ready == 1'b1, {req, " ready"}, int'(req_ready), 1);
        req_valid = 1'b1; req_op = 2'(op); req_line = 2'(ln); req_node = 2'(nd);
        @(negedge clk);
        req_valid = 1'b0;
        check(op_done == 1'b1, {req, " done"}, int'(op_done), 1);
        if (op == 0) ref_read(ln, nd);
        else if (op == 2) ref_evict(ln, nd);
        check_lists(req);
    endtask

    task automatic write_op(input int ln, input int nd, input int dly, input string req);
        int seen, guard;
        exp_cnt = 0;
        for (int i = 0; i < cnt[ln]; i++)
            if (ord[ln][i] != nd) begin exp_inv[exp_cnt] = ord[ln][i]; exp_cnt++; end
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_line = 2'(ln); req_node = 2'(nd);
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0; guard = 0;
        while (!op_done && guard < 200) begin
            if (inv_valid) begin
                int held;
                held = int'(inv_node);
                check(seen < exp_cnt && held == exp_inv[seen] && int'(inv_line) == ln,
                      "R4 order", held, (seen < exp_cnt) ? exp_inv[seen] : -1);
                check(held != nd, "R6 writer spared", held, nd);
                for (int d = 0; d < dly; d++) begin
                    req_valid = 1'b1; req_op = 2'd0; req_line = 2'((ln + 1) % L); req_node = 2'(d % N);
                    @(negedge clk);
                    req_valid = 1'b0;
                    check(req_ready == 1'b0, "R10 busy", int'(req_ready), 0);
                    check(inv_valid && int'(inv_node) == held, "R5 held", int'(inv_node), held);
                end
                seen++;
                inv_ack = 1'b1;
                @(negedge clk);
                inv_ack = 1'b0;
            end else begin
                @(negedge clk);
            end
            guard++;
        end
        check(op_done == 1'b1 && seen == exp_cnt, "R4 count", seen, exp_cnt);
        ord[ln][0] = nd;
        cnt[ln] = 1;
        check_lists({req, " R6 sole"});
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < L; l++) cnt[l] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 / R11: empty lists, null pointer value 7
        check(req_ready == 1'b1 && inv_valid == 1'b0, "R1 idle", int'(inv_valid), 0);
        check_lists("R1 R11");

        // R2: front insertion order 2,0,3,1 on line 0
        simple_op(0, 0, 2, "R2");
        simple_op(0, 0, 0, "R2");
        simple_op(0, 0, 3, "R2");
        simple_op(0, 0, 1, "R2");
        // R3: repeated read by a sharer
        simple_op(0, 0, 0, "R3");
        // list is 1,3,0,2
        simple_op(2, 0, 3, "R7 middle");
        simple_op(2, 0, 1, "R8 head");
        simple_op(2, 0, 2, "R7 tail");
        simple_op(2, 0, 1, "R9 stranger");
        simple_op(3, 0, 2, "R9 noop code");
        simple_op(2, 0, 0, "R8 last");

        // R4/R5/R6/R10: writer in the middle, stalled acks
        simple_op(0, 1, 2, "R2");
        simple_op(0, 1, 1, "R2");
        simple_op(0, 1, 0, "R2");
        simple_op(0, 1, 3, "R2");
        write_op(1, 1, 2, "R4 mid writer");
        // empty list write
        write_op(2, 3, 0, "R6 empty");
        // writer absent, three sharers
        simple_op(0, 3, 0, "R2");
        simple_op(0, 3, 1, "R2");
        simple_op(0, 3, 2, "R2");
        write_op(3, 3, 1, "R4 absent writer");

        // sweep
        for (int it = 0; it < 500; it++) begin
            int sel, ln, nd, dly;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sel = int'(lfsr[2:0]);
            ln  = int'(lfsr[4:3]);
            nd  = int'(lfsr[6:5]);
            dly = int'(lfsr[9:8]) % 3;
            if (sel < 4)      simple_op(0, ln, nd, "R2 sweep");
            else if (sel < 6) simple_op(2, ln, nd, "R7 sweep");
            else              write_op(ln, nd, dly, "R4 sweep");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule